// File: doc/BRIEF.md
# Linear Chain Claiming Controller

This controller sits beside one processing element of a 2D mesh. It takes part in a distributed protocol that builds a chain of linearly connected elements. A request to claim N elements arrives on one of five message ports: the four mesh neighbours, plus a local port used by the element's own program to start a chain. The controller claims its own element. It then hands the request, with the count lowered by one, to a single free neighbour. The next neighbour is picked by a heading-following policy, a row-reversing policy or a pseudo-random policy.

Responses return hop by hop along the same chain. The last element answers with an acknowledge. Each element on the way back adds itself to the count in the acknowledge. A dead end answers with a reject, and every element on the return path that receives the reject drops its claim. After the region has been used, a retreat message from the chain's predecessor walks down the chain and releases it. Neighbour occupancy, including mesh edges, is supplied as a busy vector. A separate input marks the local element as in use by someone else.

Top module: `lin_invade_ctrl`

## Requirements
- R1: A message is COUNT_W+7 bits wide. Its fields are: op in bits [COUNT_W+6:COUNT_W+5] (0 invade, 1 retreat, 2 acknowledge, 3 reject); strategy in bit [COUNT_W+4] (0 linear); policy in [COUNT_W+3:COUNT_W+2] (0 straight, 1 random, 2 meander, 3 invalid); heading in [COUNT_W+1:COUNT_W]; count in [COUNT_W-1:0]. Ports 0..3 are the north, east, south and west neighbours, with direction codes N=0, E=1, S=2, W=3. Port 4 is local. A forwarded invade keeps the policy it arrived with.
- R2: After reset the phase is 0 (idle), the claim flag is low and no port transmits.
- R3: A valid invade with count above one, sampled at edge k while idle, sets phase 1 after edge k. After edge k+1 it sends exactly one invade, carrying count-1, to a free neighbour. The sender of the invade (the parent) is never chosen.
- R4: An invade with count one claims the element. After edge k+1 it returns an acknowledge with count 1 to the parent, and the phase becomes 2 (execute).
- R5: The straight policy forwards along the incoming heading when that neighbour is free. Otherwise it takes the first free direction going clockwise (N, E, S, W) from the heading. The outgoing heading is the chosen direction.
- R6: The meander policy forwards along the heading when that neighbour is free. Otherwise it tries south, then north, and on that move sends the reversed heading (code XOR 2). If neither is free, it falls back to the clockwise search.
- R7: The random policy forwards to one free, non-parent neighbour, chosen from a start point given by an internal LFSR.
- R8: If count is above one and no neighbour is free, a reject goes to the parent after edge k+1, and the element returns to idle with its claim released.
- R9: An invade is answered with a reject one edge after it is sampled, with no change of phase, in any of these cases: the element is not idle; the self-busy input is high; the strategy is not linear; the policy is 3; or the count is 0.
- R10: When several invades arrive together while idle, the lowest port index wins. Every other port is rejected after the first edge.
- R11: While waiting, an acknowledge from the child goes to the parent with count+1, and the phase becomes 2. A reject from the child goes to the parent, and the element returns to idle.
- R12: A retreat from the parent while in phase 2 sets phase 3 for one cycle. The element then sends a retreat to its child, if it has one, and returns to idle.
- R13: An acknowledge not sent by the child, or a retreat not sent by the parent, causes no transmission and no change of phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| self_busy_i | input | 1 | Local element is held by another application |
| nbr_busy_i | input | 4 | Neighbour unavailable (N,E,S,W), including mesh edges |
| rx_valid_i | input | 5 | Message strobe per port (N,E,S,W,local) |
| rx_msg_i | input | 5*(COUNT_W+7) | Incoming messages, port p in slice p |
| tx_valid_o | output | 5 | Outgoing message strobe per port, one-cycle pulse |
| tx_msg_o | output | 5*(COUNT_W+7) | Outgoing messages, port p in slice p |
| claimed_o | output | 1 | Element is claimed by a chain |
| phase_o | output | 2 | 0 idle, 1 invade, 2 execute, 3 retreat |

## Verification
The forwarding step is tested against several busy patterns:
- All neighbours free, to confirm that the heading is kept.
- The heading blocked, which separates the clockwise search of the straight policy from the south/north turn of the meander policy, including its reversed heading.
- South also blocked, which shows that the meander policy falls back to north.
- Every non-parent side blocked, which exposes the dead-end reject.

For the random policy, a pattern with one free side pins down the result. Patterns with two free sides check that the choice always stays inside the free set. Acknowledge, reject and retreat are each sent from both the right port and the wrong port, which shows that only the parent-child link is obeyed.

// File: rtl/lic_pkg.sv
`timescale 1ns/1ps
package lic_pkg;
  localparam int NDIR  = 4;
  localparam int NPORT = 5;

  localparam logic [1:0] OP_INVADE  = 2'd0;
  localparam logic [1:0] OP_RETREAT = 2'd1;
  localparam logic [1:0] OP_ACK     = 2'd2;
  localparam logic [1:0] OP_REJECT  = 2'd3;

  localparam logic [1:0] POL_STRAIGHT = 2'd0;
  localparam logic [1:0] POL_RANDOM   = 2'd1;
  localparam logic [1:0] POL_MEANDER  = 2'd2;

  localparam logic [1:0] DIR_N = 2'd0;
  localparam logic [1:0] DIR_S = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_WAIT, ST_EXEC, ST_RETREAT
  } state_e;

  // {found, dir}: first free direction clockwise from start
  function automatic logic [2:0] first_free(logic [3:0] free, logic [1:0] start);
    logic [1:0] d;
    for (int i = 0; i < 4; i++) begin
      d = start + i[1:0];
      if (free[d]) return {1'b1, d};
    end
    return 3'b000;
  endfunction
endpackage

// File: rtl/lic_lfsr.sv
`timescale 1ns/1ps
module lic_lfsr #(
  parameter logic [7:0] SEED = 8'hA5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [1:0] rnd_o
);
  localparam int W = 8;
  logic [W-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= SEED;
    else         s_q <= {s_q[W-2:0], s_q[7] ^ s_q[5] ^ s_q[4] ^ s_q[3]};
  end

  assign rnd_o = s_q[1:0];

  assert_lfsr_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni) s_q != '0);
endmodule

// File: rtl/lic_rx_decode.sv
`timescale 1ns/1ps
module lic_rx_decode import lic_pkg::*; #(
  parameter int COUNT_W = 6,
  localparam int MSG_W = COUNT_W + 7
) (
  input  logic [NPORT-1:0]              rx_valid_i,
  input  logic [NPORT*MSG_W-1:0]        rx_msg_i,
  output logic [NPORT-1:0]              inv_o,
  output logic [NPORT-1:0][1:0]         op_o,
  output logic [NPORT-1:0]              strat_o,
  output logic [NPORT-1:0][1:0]         pol_o,
  output logic [NPORT-1:0][1:0]         head_o,
  output logic [NPORT-1:0][COUNT_W-1:0] cnt_o,
  output logic                          win_valid_o,
  output logic [2:0]                    win_port_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [MSG_W-1:0] m;
    assign m          = rx_msg_i[p*MSG_W +: MSG_W];
    assign op_o[p]    = m[COUNT_W+5 +: 2];
    assign strat_o[p] = m[COUNT_W+4];
    assign pol_o[p]   = m[COUNT_W+2 +: 2];
    assign head_o[p]  = m[COUNT_W +: 2];
    assign cnt_o[p]   = m[COUNT_W-1:0];
    assign inv_o[p]   = rx_valid_i[p] && (m[COUNT_W+5 +: 2] == OP_INVADE);
  end

  // lowest port index wins
  always_comb begin
    win_valid_o = 1'b0;
    win_port_o  = '0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (inv_o[p]) begin
        win_valid_o = 1'b1;
        win_port_o  = p[2:0];
      end
    end
  end
endmodule

// File: rtl/lic_nbr_select.sv
`timescale 1ns/1ps
module lic_nbr_select import lic_pkg::*; (
  input  logic [NDIR-1:0] free_i,
  input  logic [1:0]      policy_i,
  input  logic [1:0]      head_i,
  input  logic [1:0]      rnd_i,
  output logic            found_o,
  output logic [1:0]      dir_o,
  output logic [1:0]      head_o
);
  logic [2:0] cw_head, cw_rnd;
  assign cw_head = first_free(free_i, head_i);
  assign cw_rnd  = first_free(free_i, rnd_i);

  always_comb begin
    {found_o, dir_o} = cw_head;
    head_o = cw_head[1:0];
    unique case (policy_i)
      POL_RANDOM: begin
        {found_o, dir_o} = cw_rnd;
        head_o = cw_rnd[1:0];
      end
      POL_MEANDER: begin
        if (free_i[head_i]) begin
          found_o = 1'b1; dir_o = head_i; head_o = head_i;
        end else if (free_i[DIR_S]) begin
          found_o = 1'b1; dir_o = DIR_S; head_o = head_i ^ 2'd2;
        end else if (free_i[DIR_N]) begin
          found_o = 1'b1; dir_o = DIR_N; head_o = head_i ^ 2'd2;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    assert_sel_free_R5: assert (!found_o || free_i[dir_o]);
  end
endmodule

// File: rtl/lin_invade_ctrl.sv
`timescale 1ns/1ps
module lin_invade_ctrl import lic_pkg::*; #(
  parameter int         COUNT_W   = 6,
  parameter logic [7:0] LFSR_SEED = 8'hA5,
  localparam int        MSG_W     = COUNT_W + 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   self_busy_i,
  input  logic [3:0]             nbr_busy_i,
  input  logic [4:0]             rx_valid_i,
  input  logic [5*MSG_W-1:0]     rx_msg_i,
  output logic [4:0]             tx_valid_o,
  output logic [5*MSG_W-1:0]     tx_msg_o,
  output logic                   claimed_o,
  output logic [1:0]             phase_o
);
  logic [NPORT-1:0]              inv_vec;
  logic [NPORT-1:0][1:0]         rx_op, rx_pol, rx_head;
  logic [NPORT-1:0]              rx_strat;
  logic [NPORT-1:0][COUNT_W-1:0] rx_cnt;
  logic                          win_valid;
  logic [2:0]                    win_port;

  lic_rx_decode #(.COUNT_W(COUNT_W)) u_dec (
    .rx_valid_i (rx_valid_i),
    .rx_msg_i   (rx_msg_i),
    .inv_o      (inv_vec),
    .op_o       (rx_op),
    .strat_o    (rx_strat),
    .pol_o      (rx_pol),
    .head_o     (rx_head),
    .cnt_o      (rx_cnt),
    .win_valid_o(win_valid),
    .win_port_o (win_port)
  );

  state_e               state_q, state_d;
  logic [2:0]           parent_q, parent_d;
  logic [1:0]           child_q, child_d;
  logic                 has_child_q, has_child_d;
  logic [1:0]           pol_q, pol_d, head_q, head_d;
  logic [COUNT_W-1:0]   cnt_q, cnt_d;
  logic [NPORT-1:0]              tx_v_q, tx_v_d;
  logic [NPORT-1:0][MSG_W-1:0]   tx_m_q, tx_m_d;

  logic [1:0] rnd;
  lic_lfsr #(.SEED(LFSR_SEED)) u_lfsr (.clk_i(clk_i), .rst_ni(rst_ni), .rnd_o(rnd));

  logic [3:0] parent_mask, free_dirs;
  logic       sel_found;
  logic [1:0] sel_dir, sel_head;
  assign parent_mask = (parent_q < 3'd4) ? (4'b0001 << parent_q[1:0]) : 4'b0000;
  // neighbours invading us this cycle are claimed: never pick them
  assign free_dirs   = ~nbr_busy_i & ~inv_vec[3:0] & ~parent_mask;

  lic_nbr_select u_sel (
    .free_i  (free_dirs),
    .policy_i(pol_q),
    .head_i  (head_q),
    .rnd_i   (rnd),
    .found_o (sel_found),
    .dir_o   (sel_dir),
    .head_o  (sel_head)
  );

  function automatic logic [MSG_W-1:0] mk_msg(logic [1:0] op, logic [1:0] pol,
                                              logic [1:0] head, logic [COUNT_W-1:0] cnt);
    return {op, 1'b0, pol, head, cnt};
  endfunction

  logic cmd_ok, accept;
  assign cmd_ok = !rx_strat[win_port] && (rx_pol[win_port] != 2'd3) && (rx_cnt[win_port] != '0);
  assign accept = (state_q == ST_IDLE) && win_valid && !self_busy_i && cmd_ok;

  always_comb begin
    state_d     = state_q;
    parent_d    = parent_q;
    child_d     = child_q;
    has_child_d = has_child_q;
    pol_d       = pol_q;
    head_d      = head_q;
    cnt_d       = cnt_q;
    tx_v_d      = '0;
    tx_m_d      = '0;

    for (int p = 0; p < NPORT; p++) begin
      if (inv_vec[p] && !(accept && (win_port == p[2:0]))) begin
        tx_v_d[p] = 1'b1;
        tx_m_d[p] = mk_msg(OP_REJECT, 2'd0, 2'd0, '0);
      end
    end

    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d  = ST_DECIDE;
        parent_d = win_port;
        pol_d    = rx_pol[win_port];
        head_d   = rx_head[win_port];
        cnt_d    = rx_cnt[win_port];
      end
      ST_DECIDE: begin
        if (cnt_q == COUNT_W'(1)) begin
          tx_v_d[parent_q] = 1'b1;
          tx_m_d[parent_q] = mk_msg(OP_ACK, 2'd0, 2'd0, COUNT_W'(1));
          has_child_d      = 1'b0;
          state_d          = ST_EXEC;
        end else if (sel_found) begin
          tx_v_d[sel_dir] = 1'b1;
          tx_m_d[sel_dir] = mk_msg(OP_INVADE, pol_q, sel_head, cnt_q - 1'b1);
          child_d         = sel_dir;
          has_child_d     = 1'b1;
          state_d         = ST_WAIT;
        end else begin
          tx_v_d[parent_q] = 1'b1;
          tx_m_d[parent_q] = mk_msg(OP_REJECT, 2'd0, 2'd0, '0);
          has_child_d      = 1'b0;
          state_d          = ST_IDLE;
        end
      end
      ST_WAIT: if (rx_valid_i[{1'b0, child_q}]) begin
        if (rx_op[{1'b0, child_q}] == OP_ACK) begin
          tx_v_d[parent_q] = 1'b1;
          tx_m_d[parent_q] = mk_msg(OP_ACK, 2'd0, 2'd0, rx_cnt[{1'b0, child_q}] + 1'b1);
          state_d          = ST_EXEC;
        end else if (rx_op[{1'b0, child_q}] == OP_REJECT) begin
          tx_v_d[parent_q] = 1'b1;
          tx_m_d[parent_q] = mk_msg(OP_REJECT, 2'd0, 2'd0, '0);
          has_child_d      = 1'b0;
          state_d          = ST_IDLE;
        end
      end
      ST_EXEC: if (rx_valid_i[parent_q] && rx_op[parent_q] == OP_RETREAT) state_d = ST_RETREAT;
      ST_RETREAT: begin
        if (has_child_q) begin
          tx_v_d[child_q] = 1'b1;
          tx_m_d[child_q] = mk_msg(OP_RETREAT, 2'd0, 2'd0, '0);
        end
        has_child_d = 1'b0;
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      parent_q    <= '0;
      child_q     <= '0;
      has_child_q <= 1'b0;
      pol_q       <= '0;
      head_q      <= '0;
      cnt_q       <= '0;
      tx_v_q      <= '0;
      tx_m_q      <= '0;
    end else begin
      state_q     <= state_d;
      parent_q    <= parent_d;
      child_q     <= child_d;
      has_child_q <= has_child_d;
      pol_q       <= pol_d;
      head_q      <= head_d;
      cnt_q       <= cnt_d;
      tx_v_q      <= tx_v_d;
      tx_m_q      <= tx_m_d;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_tx
    assign tx_msg_o[p*MSG_W +: MSG_W] = tx_m_q[p];
  end
  assign tx_valid_o = tx_v_q;
  assign claimed_o  = (state_q != ST_IDLE);
  always_comb begin
    unique case (state_q)
      ST_IDLE:            phase_o = 2'd0;
      ST_DECIDE, ST_WAIT: phase_o = 2'd1;
      ST_EXEC:            phase_o = 2'd2;
      default:            phase_o = 2'd3;
    endcase
  end

  // checks
  logic [3:0] fwd_inv;
  for (genvar d = 0; d < NDIR; d++) begin : g_chk
    assign fwd_inv[d] = tx_valid_o[d] && (tx_msg_o[d*MSG_W+COUNT_W+5 +: 2] == OP_INVADE);
    assert_fwd_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fwd_inv[d] |-> $past(!nbr_busy_i[d]));
  end

  assert_one_fwd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(fwd_inv) <= 1);
  assert_claim_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(claimed_o) |-> ($past(|rx_valid_i) && !$past(self_busy_i)));
  assert_retreat_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd3) |=> (phase_o == 2'd0));
  assert_no_tx_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_o) == 2'd0 && $past(rx_valid_i) == '0) |-> (tx_valid_o == '0));
endmodule

// File: tb/lin_invade_ctrl_tb.sv
`timescale 1ns/1ps
module lin_invade_ctrl_tb;
  localparam int CW = 6;
  localparam int MW = CW + 7;
  localparam logic [1:0] INV = 2'd0, RET = 2'd1, ACK = 2'd2, REJ = 2'd3;
  localparam logic [1:0] STR = 2'd0, RND = 2'd1, MEA = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0, self_busy = 1'b0;
  logic [3:0] nbr_busy = '0;
  logic [4:0] rx_valid = '0, tx_valid;
  logic [5*MW-1:0] rx_msg = '0, tx_msg;
  logic claimed;
  logic [1:0] phase;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lin_invade_ctrl #(.COUNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .self_busy_i(self_busy), .nbr_busy_i(nbr_busy),
    .rx_valid_i(rx_valid), .rx_msg_i(rx_msg), .tx_valid_o(tx_valid), .tx_msg_o(tx_msg),
    .claimed_o(claimed), .phase_o(phase));

  function automatic logic [MW-1:0] mk(logic [1:0] op, logic st, logic [1:0] pol,
                                       logic [1:0] hd, logic [CW-1:0] cnt);
    return {op, st, pol, hd, cnt};
  endfunction
  function automatic int op_of(int p);   return int'(tx_msg[p*MW+CW+5 +: 2]); endfunction
  function automatic int pol_of(int p);  return int'(tx_msg[p*MW+CW+2 +: 2]); endfunction
  function automatic int head_of(int p); return int'(tx_msg[p*MW+CW +: 2]); endfunction
  function automatic int cnt_of(int p);  return int'(tx_msg[p*MW +: CW]); endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(int p, logic [MW-1:0] m);
    rx_valid[p] = 1'b1;
    rx_msg[p*MW +: MW] = m;
  endtask

  task automatic step();
    @(posedge clk); #1;
    rx_valid = '0;
    @(negedge clk);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0; self_busy = 1'b0; nbr_busy = '0; rx_valid = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R2 phase", int'(phase), 0);
    chk("R2 claimed", int'(claimed), 0);
    chk("R2 tx_valid", int'(tx_valid), 0);
  endtask

  task automatic t_straight_chain();
    reset_dut();
    drive(4, mk(INV, 0, STR, 2'd1, 6'd5));
    step();
    chk("R3 phase invade", int'(phase), 1);
    chk("R3 no tx yet", int'(tx_valid), 0);
    step();
    chk("R3 fwd port E", int'(tx_valid), 5'b00010);
    chk("R1 op invade", op_of(1), 0);
    chk("R3 count-1", cnt_of(1), 4);
    chk("R5 keeps heading", head_of(1), 1);
    chk("R1 policy kept", pol_of(1), 0);
    drive(3, mk(ACK, 0, 0, 0, 6'd9));
    step();
    chk("R13 stray ack no tx", int'(tx_valid), 0);
    chk("R13 stray ack phase", int'(phase), 1);
    drive(1, mk(ACK, 0, 0, 0, 6'd4));
    step();
    chk("R11 ack to local", int'(tx_valid), 5'b10000);
    chk("R11 ack op", op_of(4), 2);
    chk("R11 ack count+1", cnt_of(4), 5);
    chk("R11 phase execute", int'(phase), 2);
    drive(2, mk(INV, 0, STR, 0, 6'd3));
    step();
    chk("R9 claimed reject port", int'(tx_valid), 5'b00100);
    chk("R9 claimed reject op", op_of(2), 3);
    chk("R9 phase kept", int'(phase), 2);
    drive(1, mk(RET, 0, 0, 0, 0));
    step();
    chk("R13 stray retreat phase", int'(phase), 2);
    chk("R13 stray retreat tx", int'(tx_valid), 0);
    drive(4, mk(RET, 0, 0, 0, 0));
    step();
    chk("R12 phase retreat", int'(phase), 3);
    chk("R12 no tx yet", int'(tx_valid), 0);
    step();
    chk("R12 retreat to child", int'(tx_valid), 5'b00010);
    chk("R12 retreat op", op_of(1), 1);
    chk("R12 idle", int'(phase), 0);
    chk("R12 released", int'(claimed), 0);
  endtask

  task automatic t_straight_blocked();
    reset_dut();
    nbr_busy = 4'b0010;
    drive(4, mk(INV, 0, STR, 2'd1, 6'd3));
    step(); step();
    chk("R5 clockwise to S", int'(tx_valid), 5'b00100);
    chk("R5 heading S", head_of(2), 2);
  endtask

  task automatic t_meander();
    reset_dut();
    nbr_busy = 4'b0010;
    drive(3, mk(INV, 0, MEA, 2'd1, 6'd3));
    step(); step();
    chk("R6 turn south", int'(tx_valid), 5'b00100);
    chk("R6 reversed heading", head_of(2), 3);
    chk("R6 policy kept", pol_of(2), 2);
    drive(2, mk(REJ, 0, 0, 0, 0));
    step();
    chk("R11 reject to parent W", int'(tx_valid), 5'b01000);
    chk("R11 reject op", op_of(3), 3);
    chk("R11 released", int'(phase), 0);
    reset_dut();
    nbr_busy = 4'b0110;
    drive(3, mk(INV, 0, MEA, 2'd1, 6'd3));
    step(); step();
    chk("R6 north fallback", int'(tx_valid), 5'b00001);
    chk("R6 north heading", head_of(0), 3);
  endtask

  task automatic t_dead_end();
    reset_dut();
    nbr_busy = 4'b0111;
    drive(3, mk(INV, 0, MEA, 2'd1, 6'd2));
    step();
    chk("R8 claimed meanwhile", int'(claimed), 1);
    step();
    chk("R8 reject to parent", int'(tx_valid), 5'b01000);
    chk("R8 reject op", op_of(3), 3);
    chk("R8 released", int'(claimed), 0);
  endtask

  task automatic t_terminal();
    reset_dut();
    nbr_busy = 4'b1111;
    drive(0, mk(INV, 0, STR, 2'd2, 6'd1));
    step(); step();
    chk("R4 ack to N", int'(tx_valid), 5'b00001);
    chk("R4 ack op", op_of(0), 2);
    chk("R4 ack count", cnt_of(0), 1);
    chk("R4 phase execute", int'(phase), 2);
    drive(0, mk(RET, 0, 0, 0, 0));
    step();
    chk("R12 terminal retreat phase", int'(phase), 3);
    step();
    chk("R12 terminal no tx", int'(tx_valid), 0);
    chk("R12 terminal idle", int'(phase), 0);
  endtask

  task automatic t_random();
    reset_dut();
    nbr_busy = 4'b1110;
    drive(4, mk(INV, 0, RND, 2'd1, 6'd4));
    step(); step();
    chk("R7 only free side", int'(tx_valid), 5'b00001);
    chk("R7 policy kept", pol_of(0), 1);
    for (int i = 0; i < 6; i++) begin
      reset_dut();
      repeat (i) @(negedge clk);
      nbr_busy = 4'b1010;
      drive(4, mk(INV, 0, RND, 2'd0, 6'd4));
      step(); step();
      chk("R7 choice in free set",
          int'(tx_valid == 5'b00001 || tx_valid == 5'b00100), 1);
    end
  endtask

  task automatic t_rejects();
    reset_dut();
    self_busy = 1'b1;
    drive(1, mk(INV, 0, STR, 0, 6'd3));
    step();
    chk("R9 self busy reject", int'(tx_valid), 5'b00010);
    chk("R9 self busy op", op_of(1), 3);
    chk("R9 self busy phase", int'(phase), 0);
    self_busy = 1'b0;
    drive(1, mk(INV, 0, 2'd3, 0, 6'd3));
    step();
    chk("R9 bad policy reject", op_of(1), 3);
    chk("R9 bad policy phase", int'(phase), 0);
    drive(1, mk(INV, 0, STR, 0, 6'd0));
    step();
    chk("R9 zero count reject", int'(tx_valid), 5'b00010);
    chk("R9 zero count phase", int'(phase), 0);
    drive(1, mk(INV, 1'b1, STR, 0, 6'd3));
    step();
    chk("R9 rect strategy reject", int'(tx_valid), 5'b00010);
    chk("R9 rect strategy phase", int'(phase), 0);
  endtask

  task automatic t_collision();
    reset_dut();
    drive(0, mk(INV, 0, STR, 2'd2, 6'd1));
    drive(1, mk(INV, 0, STR, 2'd3, 6'd1));
    step();
    chk("R10 loser rejected", int'(tx_valid), 5'b00010);
    chk("R10 loser op", op_of(1), 3);
    chk("R10 winner claims", int'(phase), 1);
    step();
    chk("R10 winner acked", int'(tx_valid), 5'b00001);
    chk("R10 winner ack op", op_of(0), 2);
  endtask

  initial begin
    t_reset();
    t_straight_chain();
    t_straight_blocked();
    t_meander();
    t_dead_end();
    t_terminal();
    t_random();
    t_rejects();
    t_collision();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule